// File: doc/BRIEF.md
# Clocked Controller for a 16-bit Asynchronous Static RAM

This block sits between a synchronous request port and an external asynchronous static RAM of one million 16-bit words. A requester presents a read or a write with a word address, two byte-lane enables and write data using a valid/ready handshake. The controller then steps the memory pins through a timed sequence. Two chip selects of opposite polarity, a write strobe, an output-enable strobe and two byte-lane strobes are all driven from registers. The data bus is split into an outgoing value, an incoming value and a drive enable for the pad.

Every wait is counted in clock cycles. Each count is the nanosecond limit divided by the clock period, rounded up, with a floor of one cycle. With the defaults (4 ns clock; 45 ns access, 35 ns write pulse, 28 ns data setup, 18 ns high-impedance time) this gives 12 read-access cycles, 9 write-pulse cycles and 5 turnaround cycles. The output enable stays high through every write cycle, so the memory never drives the bus while the controller does.

The sequencer has five named states:
- IDLE: ready is high and the memory is deselected.
- RD_ACC: read access.
- TURN: the memory is deselected while its outputs float.
- WR_PULSE: write strobe low.
- WR_HOLD: strobes high, data still driven.

The transitions are:
- IDLE to RD_ACC on an accepted read.
- IDLE to WR_PULSE on an accepted write.
- RD_ACC to TURN when the access count expires.
- TURN to IDLE when the turnaround count expires.
- WR_PULSE to WR_HOLD when the pulse count expires.
- WR_HOLD to IDLE after one cycle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and at the first cycle after it, the outputs are in their idle values: mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1, mem_lo_n=1, mem_hi_n=1, mem_dq_oe=0, rsp_valid=0 and req_ready=1.
- R2: Both chip selects are active together (mem_sel_n=0 with mem_sel=1) only during a read access or a write pulse. Whenever req_ready is high, both are inactive.
- R3: An accepted read holds the following for exactly RD_CYC consecutive cycles: mem_addr equal to the request address, mem_rd_n=0, mem_wr_n=1, mem_lo_n equal to the inverse of req_be[0] (lane bits 7:0) and mem_hi_n equal to the inverse of req_be[1] (lane bits 15:8).
- R4: Read data is sampled from mem_dq_in at the end of the last access cycle. It appears on rsp_rdata with a one-cycle rsp_valid pulse in the cycle after that, which is the (RD_CYC+1)th cycle after acceptance. Lanes whose enable is 0 read as zero.
- R5: An accepted write with at least one lane enabled drives mem_wr_n low for exactly WP_CYC cycles. During that pulse the lane strobes follow the enables and mem_dq_out carries the write data. mem_rd_n stays high for the whole write.
- R6: mem_dq_oe is high during the write pulse and for exactly one cycle after mem_wr_n returns high. It is low at every other time, and never high while mem_rd_n is low.
- R7: A write changes only the byte lanes whose enable is set. The other lanes keep their earlier contents, which is observable by reading back.
- R8: After a read is accepted, req_ready stays low for RD_CYC+TA_CYC cycles, which includes the idle turnaround before any next request.
- R9: req_ready is high only in idle. A request is taken on a clock edge where req_valid and req_ready are both high. After a write is accepted, req_ready stays low for WP_CYC+1 cycles.
- R10: RD_CYC, WP_CYC and TA_CYC are each max(1, ceil(limit/period)). WP_CYC uses the larger of the write-pulse and data-setup limits. With the defaults, RD_CYC=12, WP_CYC=9 and TA_CYC=5.
- R11: A write with both enables 0 produces no write pulse, does not drive the bus and leaves the memory unchanged. A read with both enables 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_lo_n | output | 1 | Active-low strobe for bits 7:0 |
| mem_hi_n | output | 1 | Active-low strobe for bits 15:8 |

## Verification
Each fault in the sequencer has a distinct effect at the ports:
- A stuck or skipped state shows within one transaction as a wrong number of busy cycles on req_ready.
- A miscounted timer shows as an output-enable or write-strobe window whose length differs from the computed cycle count.
- A lost request latch shows as an address or lane strobe that changes partway through an access.
- A wrong capture point or lane mask surfaces at the next readback of that word, as data that differs from the value the bench expects.

Bus contention, meaning mem_dq_oe high while the memory is enabled to drive, would be visible in the very cycle it starts.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // Cycles needed to cover a time limit, rounded up, never below one.
    function automatic int cycles_for(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 12,
    parameter int WP_CYC = 9,
    parameter int TA_CYC = 5,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output ctl_state_e       state,
    output ctl_state_e       state_nxt,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load  = 1'b1;
                    state_nxt = req_write ? ST_WR_PULSE : ST_RD_ACC;
                    tmr_val   = req_write ? WP_LOAD : RD_LOAD;
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    state_nxt = ST_TURN;
                    tmr_load  = 1'b1;
                    tmr_val   = TA_LOAD;
                end
            end
            ST_TURN: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_done) state_nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  ctl_state_e        state,
    input  ctl_state_e        state_nxt,
    input  logic              tmr_done,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic [LANES-1:0]  nxt_be;
    logic [DATA_W-1:0] nxt_wdata;
    logic [DATA_W-1:0] lane_mask;
    logic              nxt_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    assign nxt_addr  = accept ? req_addr  : addr_q;
    assign nxt_be    = accept ? req_be    : be_q;
    assign nxt_wdata = accept ? req_wdata : wdata_q;
    assign nxt_any   = |nxt_be;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    // Pin registers, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b0;
            mem_wr_n   <= 1'b1;
            mem_rd_n   <= 1'b1;
            mem_lo_n   <= 1'b1;
            mem_hi_n   <= 1'b1;
        end else begin
            mem_addr   <= nxt_addr;
            mem_dq_out <= nxt_wdata;
            mem_dq_oe  <= 1'b0;
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b0;
            mem_wr_n   <= 1'b1;
            mem_rd_n   <= 1'b1;
            mem_lo_n   <= 1'b1;
            mem_hi_n   <= 1'b1;
            unique case (state_nxt)
                ST_RD_ACC: begin
                    mem_sel_n <= 1'b0;
                    mem_sel   <= 1'b1;
                    mem_rd_n  <= 1'b0;
                    mem_lo_n  <= ~nxt_be[0];
                    mem_hi_n  <= ~nxt_be[1];
                end
                ST_WR_PULSE: begin
                    mem_sel_n <= ~nxt_any;
                    mem_sel   <= nxt_any;
                    mem_wr_n  <= ~nxt_any;
                    mem_dq_oe <= nxt_any;
                    mem_lo_n  <= ~nxt_be[0];
                    mem_hi_n  <= ~nxt_be[1];
                end
                ST_WR_HOLD: begin
                    mem_dq_oe <= nxt_any;
                end
                ST_IDLE, ST_TURN: begin
                    mem_dq_oe <= 1'b0;
                end
                default: mem_dq_oe <= 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_RD_ACC) && tmr_done;
            if ((state == ST_RD_ACC) && tmr_done) begin
                rsp_rdata <= mem_dq_in & lane_mask;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_ACCESS_NS   = 45,
    parameter int T_WPULSE_NS   = 35,
    parameter int T_DSETUP_NS   = 28,
    parameter int T_HIZ_NS      = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    input  logic [15:0]       mem_dq_in,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n
);
    localparam int RD_CYC = cycles_for(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC = max2(cycles_for(T_WPULSE_NS, CLK_PERIOD_NS),
                                 cycles_for(T_DSETUP_NS, CLK_PERIOD_NS));
    localparam int TA_CYC = cycles_for(T_HIZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, TA_CYC));
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    ctl_state_e       state;
    ctl_state_e       state_nxt;
    logic             accept;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    sram_ctl_fsm #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .state     (state),
        .state_nxt (state_nxt),
        .req_ready (req_ready),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_pins #(
        .ADDR_W (ADDR_W)
    ) i_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .state      (state),
        .state_nxt  (state_nxt),
        .tmr_done   (tmr_done),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n),
        .mem_lo_n   (mem_lo_n),
        .mem_hi_n   (mem_hi_n),
        .rsp_rdata  (rsp_rdata),
        .rsp_valid  (rsp_valid)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_lo_n,
    input logic              mem_hi_n
);
    AST_WRITE_KEEPS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_rd_n); // R5

    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && !(mem_lo_n && mem_hi_n))); // R5

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n); // R6

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_dq_oe); // R6

    AST_RELEASE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && mem_wr_n) |=> !mem_dq_oe); // R6

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n)); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr)); // R3

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_lo_n  (mem_lo_n),
    .mem_hi_n  (mem_hi_n)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

    localparam int PER = 4;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD = cyc(45);                               // R10: 12
    localparam int WP = (cyc(35) > cyc(28)) ? cyc(35) : cyc(28); // R10: 9
    localparam int TA = cyc(18);                               // R10: 5

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_valid;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n)
    );

    // Behavioural memory, indexed by the low address byte.
    logic [15:0] model_mem [256];
    logic [15:0] ref_mem   [256];
    logic        sel_now;
    logic        prev_wr_n = 1'b1;
    logic [7:0]  pend_idx = '0;
    logic [15:0] pend_data = '0;
    logic        pend_lo_n = 1'b1, pend_hi_n = 1'b1;
    int          fight = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = '0;
            ref_mem[i]   = '0;
        end
    end

    assign sel_now = !mem_sel_n && mem_sel;

    always_comb begin
        mem_dq_in = 16'h5A5A;
        if (sel_now && mem_wr_n && !mem_rd_n) begin
            mem_dq_in[7:0]  = mem_lo_n ? 8'h5A : model_mem[mem_addr[7:0]][7:0];
            mem_dq_in[15:8] = mem_hi_n ? 8'h5A : model_mem[mem_addr[7:0]][15:8];
        end
    end

    always @(negedge clk) begin
        if (sel_now && mem_wr_n && !mem_rd_n && mem_dq_oe) fight++;
        if (sel_now && !mem_wr_n) begin
            pend_idx  <= mem_addr[7:0];
            pend_data <= mem_dq_out;
            pend_lo_n <= mem_lo_n;
            pend_hi_n <= mem_hi_n;
        end
        if (!prev_wr_n && mem_wr_n) begin
            if (!pend_lo_n) model_mem[pend_idx][7:0]  <= pend_data[7:0];
            if (!pend_hi_n) model_mem[pend_idx][15:8] <= pend_data[15:8];
        end
        prev_wr_n <= mem_wr_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [19:0] a, input logic [1:0] be);
        logic [15:0] w;
        w = ref_mem[a[7:0]];
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic run_txn(input bit wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] wd);
        int busy = 0, rd_lo = 0, wr_lo = 0, drv = 0, nrv = 0, rv_idx = 0;
        int bad_addr = 0, bad_strb = 0, bad_data = 0;
        logic [15:0] rd = '0;
        logic [15:0] expd;
        expd = exp_read(a, be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 1000) begin
            busy++;
            if (!mem_rd_n) rd_lo++;
            if (!mem_wr_n) wr_lo++;
            if (mem_dq_oe) drv++;
            if (rsp_valid) begin nrv++; rv_idx = busy; rd = rsp_rdata; end
            if (!mem_sel_n) begin
                if (mem_addr != a) bad_addr++;
                if (mem_lo_n != !be[0] || mem_hi_n != !be[1]) bad_strb++;
            end
            if (!mem_wr_n && mem_dq_out != wd) bad_data++;
            @(negedge clk);
        end
        chk(mem_sel_n && !mem_sel, "R2 idle deselect", {mem_sel_n, mem_sel}, 2'b10);
        chk(bad_addr == 0, "R3 address held", bad_addr, 0);
        chk(bad_strb == 0, "R3 lane strobes", bad_strb, 0);
        if (!wr) begin
            chk(busy == RD + TA, "R8 read busy cycles", busy, RD + TA);
            chk(rd_lo == RD, "R3 oe window", rd_lo, RD);
            chk(wr_lo == 0 && drv == 0, "R6 no drive on read", drv + wr_lo, 0);
            chk(nrv == 1 && rv_idx == RD + 1, "R4 rvalid timing", rv_idx, RD + 1);
            if (be == 2'b00)
                chk(rd == 16'h0000, "R11 empty read", rd, 16'h0000);
            else
                chk(rd == expd, "R4 R7 read data", rd, expd);
        end else begin
            chk(busy == WP + 1, "R9 write busy cycles", busy, WP + 1);
            chk(rd_lo == 0, "R5 oe high in write", rd_lo, 0);
            chk(nrv == 0, "R4 no rvalid on write", nrv, 0);
            if (be == 2'b00) begin
                chk(wr_lo == 0, "R11 no pulse", wr_lo, 0);
                chk(drv == 0, "R11 no drive", drv, 0);
            end else begin
                chk(wr_lo == WP, "R5 pulse width", wr_lo, WP);
                chk(drv == WP + 1, "R6 drive window", drv, WP + 1);
                chk(bad_data == 0, "R5 write data", bad_data, 0);
            end
            if (be[0]) ref_mem[a[7:0]][7:0]  = wd[7:0];
            if (be[1]) ref_mem[a[7:0]][15:8] = wd[15:8];
        end
    endtask

    task automatic finish_run();
        chk(fight == 0, "R6 bus contention", fight, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: values under reset
        chk({mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n, mem_dq_oe} == 7'b1011110,
            "R1 reset pins", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n, mem_dq_oe}, 7'b1011110);
        chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe} == 5'b10110,
            "R1 after reset", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe}, 5'b10110);
        chk(RD == 12 && WP == 9 && TA == 5, "R10 derived counts", {RD[7:0], WP[7:0], TA[7:0]}, 24'h0C0905);

        // Directed corners
        run_txn(1'b1, 20'h00000, 2'b11, 16'h1234);
        run_txn(1'b0, 20'h00000, 2'b11, 16'h0000);
        run_txn(1'b1, 20'hFFFFF, 2'b11, 16'hABCD);
        run_txn(1'b0, 20'hFFFFF, 2'b11, 16'h0000);
        run_txn(1'b1, 20'hFFFFF, 2'b01, 16'h0077);  // R7 lower lane only
        run_txn(1'b0, 20'hFFFFF, 2'b11, 16'h0000);
        run_txn(1'b1, 20'hFFFFF, 2'b10, 16'h9900);  // R7 upper lane only
        run_txn(1'b0, 20'hFFFFF, 2'b10, 16'h0000);  // R4 lower lane zero
        run_txn(1'b1, 20'hFFFFF, 2'b00, 16'hFFFF);  // R11 empty write
        run_txn(1'b0, 20'hFFFFF, 2'b11, 16'h0000);
        run_txn(1'b0, 20'hFFFFF, 2'b00, 16'h0000);  // R11 empty read
        run_txn(1'b1, 20'h12345, 2'b11, 16'h5555);  // read followed by write
        run_txn(1'b1, 20'h12345, 2'b11, 16'hAAAA);  // write followed by write

        // Random mix
        for (int k = 0; k < 200; k++) begin
            run_txn(1'($urandom % 2), 20'($urandom), 2'($urandom % 4), 16'($urandom));
        end
        for (int k = 0; k < 256; k += 37) begin
            run_txn(1'b0, {12'h000, 8'(k)}, 2'b11, 16'h0000);
        end
        finish_run();
    end

endmodule